// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C) bus target that behaves like a small serial EEPROM. It samples the raw SCL and SDA lines through synchronizers and detects START and STOP conditions. It answers only to its own device select byte. It pulls SDA low through an open-drain enable whenever it acknowledges or sends a zero bit. The storage array is held in flops. Writes are collected in a page buffer and are copied into the array at the end of a modeled self-timed programming interval.

One state machine handles every transaction type:
- single-byte writes;
- page writes that wrap inside the page;
- reads at the current address;
- random reads, which use a dummy write and then a repeated START;
- sequential reads, which continue for as long as the master acknowledges.

While the programming interval runs, the target ignores the bus completely. A master finds out that the write has finished by repeating the device select until it is acknowledged.

The parameter `PAGE_SEL_BITS` sets how many of the three select bits after the fixed prefix are used as upper memory address bits instead of being compared with the strap pins:
- With 0 (the default), the array is 256 bytes with 8-byte pages.
- With 1 or 2, the array is 512 or 1024 bytes with 16-byte pages.

`PROG_CYCLES` sets the length of the programming interval in clock cycles.

Top module: `ee_twi_target`

## Requirements
- R1: A device select byte is matched when its upper four bits are 1010 and select bits 3..1 equal `strap[2:0]` (default `PAGE_SEL_BITS`=0). Bit 0 selects the direction: 1 is a read and 0 is a write. On a match the target holds SDA low during the ninth clock.
- R2: When the prefix or the strap bits do not match, the target never pulls SDA low, including for later bytes, until the next START.
- R3: In a write, the target acknowledges the word address and then every data byte. A STOP after a complete data byte starts a programming interval of `PROG_CYCLES` clocks. After that interval the written data can be read back.
- R4: During a page write only the low 3 address bits advance after each data byte, wrapping within the 8-byte page. If more than 8 bytes are sent, earlier bytes of the page are overwritten and the last byte sent wins.
- R5: During the programming interval a matching device select is not acknowledged. Once the interval ends, a matching device select is acknowledged again.
- R6: A read that starts right after the device select returns data from the internal address pointer. The pointer holds the last accessed address plus one, wrapping within the page after a write.
- R7: A random read works as follows: a write of the word address, then a repeated START, then a read that returns the byte at that address.
- R8: During a read, a master acknowledge (0) after a byte makes the target send the byte at the next address. The address wraps from the top of the array to address 0. A master no-acknowledge ends the read.
- R9: A STOP that arrives in the middle of a data byte discards the write. No programming interval starts, so the next device select is acknowledged at once, and the memory is left unchanged.
- R10: The target changes its SDA drive only while SCL is low. It releases SDA during the master's acknowledge slot.
- R11: After reset the SDA drive is released, every array byte reads 0x00 and the address pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired-AND level) |
| strap | input | 3 | Hard-wired select pins compared against select bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |

## Verification
On every cycle, the embedded assertions check the following:
- the SDA drive only turns on while the synchronized SCL is low;
- the drive stays off during the master's acknowledge slot and for the whole programming interval, during which the state machine stays idle;
- the interval counter stays in range;
- the page buffer is never written in the same cycle as a commit;
- an accepted select byte matches the strap pins.

The following can only be shown by bus scenarios in the bench, which compares the results against a reference memory and pointer:
- the data contents across page wrap and array wrap;
- the pointer value that carries over between transactions;
- the number of polls that go unacknowledged after a STOP;
- the discarding of a write that is cut off by an early STOP.

// File: rtl/ee_twi_pkg.sv
package ee_twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } ee_state_t;
endpackage

// File: rtl/ee_twi_linemon.sv
module ee_twi_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_prev <= scl_sync[1];
      sda_prev <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign bus_start = scl_s & scl_prev & sda_prev & ~sda_s;
  assign bus_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/ee_twi_store.sv
module ee_twi_store #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_din,
  input  logic              commit,
  input  logic [ADDR_W-PAGE_W-1:0] row,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PSIZE = 1 << PAGE_W;

  logic [7:0]       mem  [DEPTH];
  logic [7:0]       pbuf [PSIZE];
  logic [PSIZE-1:0] pval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      for (int i = 0; i < PSIZE; i++) pbuf[i] <= 8'h00;
      pval <= '0;
    end else begin
      if (commit) begin
        for (int i = 0; i < PSIZE; i++)
          if (pval[i]) mem[{row, PAGE_W'(i)}] <= pbuf[i];
        pval <= '0;
      end else if (buf_clr) begin
        pval <= '0;
      end else if (buf_we) begin
        pbuf[buf_idx] <= buf_din;
        pval[buf_idx] <= 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_addr];

  p_commit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !buf_we);
endmodule

// File: rtl/ee_twi_target.sv
module ee_twi_target #(
  parameter int PAGE_SEL_BITS = 0,
  parameter int PROG_CYCLES   = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap,
  output logic       sda_oe
);
  import ee_twi_pkg::*;

  localparam int ADDR_W = 8 + PAGE_SEL_BITS;
  localparam int PAGE_W = (PAGE_SEL_BITS == 0) ? 3 : 4;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  ee_state_t         st_q, st_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d, tx_q, tx_d;
  logic [3:0]        sel_q, sel_d;
  logic [ADDR_W-1:0] adr_q, adr_d;
  logic              oe_q, oe_d, more_q, more_d, pend_q, pend_d, busy_q, busy_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic              buf_clr, buf_we, commit, sel_match;
  logic [7:0]        rd_data;

  ee_twi_linemon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  ee_twi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(adr_q[PAGE_W-1:0]), .buf_din(sh_q), .commit(commit),
    .row(adr_q[ADDR_W-1:PAGE_W]), .rd_addr(adr_q), .rd_data(rd_data)
  );

  always_comb begin
    sel_match = (sh_q[7:4] == 4'b1010);
    for (int i = 0; i < 3; i++)
      if (i >= PAGE_SEL_BITS && sh_q[1+i] != strap[i]) sel_match = 1'b0;
  end

  assign commit = busy_q && (wcnt_q == CNT_LAST);

  always_comb begin
    st_d = st_q;   bit_d = bit_q;  sh_d = sh_q;     tx_d = tx_q;
    sel_d = sel_q; adr_d = adr_q;  oe_d = oe_q;     more_d = more_q;
    pend_d = pend_q; busy_d = busy_q; wcnt_d = wcnt_q;
    buf_clr = 1'b0; buf_we = 1'b0;
    if (busy_q) begin
      wcnt_d = commit ? '0 : wcnt_q + 1'b1;
      busy_d = !commit;
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
    end else if (bus_start) begin
      st_d = ST_SEL; bit_d = '0; oe_d = 1'b0; pend_d = 1'b0; buf_clr = 1'b1;
    end else if (bus_stop) begin
      st_d = ST_IDLE; oe_d = 1'b0; pend_d = 1'b0;
      if (st_q == ST_WDAT && bit_q <= 4'd1 && pend_q) begin
        busy_d = 1'b1;
        wcnt_d = '0;
      end
    end else begin
      if (scl_rise && (st_q == ST_SEL || st_q == ST_WADR || st_q == ST_WDAT)) begin
        sh_d  = {sh_q[6:0], sda_s};
        bit_d = bit_q + 1'b1;
      end
      if (scl_rise && st_q == ST_RDAT_ACK) more_d = ~sda_s;
      if (scl_fall) begin
        unique case (st_q)
          ST_SEL: if (bit_q == 4'd8) begin
            bit_d = '0;
            if (sel_match) begin
              sel_d = sh_q[3:0]; oe_d = 1'b1; st_d = ST_SEL_ACK;
            end else st_d = ST_IDLE;
          end
          ST_SEL_ACK, ST_RDAT_ACK: begin
            if ((st_q == ST_SEL_ACK && sel_q[0]) || (st_q == ST_RDAT_ACK && more_q)) begin
              tx_d = {rd_data[6:0], 1'b0}; oe_d = ~rd_data[7];
              bit_d = 4'd1; st_d = ST_RDAT;
            end else if (st_q == ST_SEL_ACK) begin
              oe_d = 1'b0; st_d = ST_WADR;
            end else st_d = ST_IDLE;
          end
          ST_WADR: if (bit_q == 4'd8) begin
            adr_d = ADDR_W'({sel_q[3:1], sh_q});
            oe_d = 1'b1; bit_d = '0; st_d = ST_WADR_ACK;
          end
          ST_WDAT: if (bit_q == 4'd8) begin
            buf_we = 1'b1; pend_d = 1'b1;
            adr_d  = {adr_q[ADDR_W-1:PAGE_W], adr_q[PAGE_W-1:0] + 1'b1};
            oe_d = 1'b1; bit_d = '0; st_d = ST_WDAT_ACK;
          end
          ST_WADR_ACK, ST_WDAT_ACK: begin
            oe_d = 1'b0; st_d = ST_WDAT;
          end
          ST_RDAT: if (bit_q == 4'd8) begin
            oe_d = 1'b0; adr_d = adr_q + 1'b1; bit_d = '0; st_d = ST_RDAT_ACK;
          end else begin
            oe_d = ~tx_q[7]; tx_d = {tx_q[6:0], 1'b0}; bit_d = bit_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; tx_q <= '0; sel_q <= '0;
      adr_q <= '0; oe_q <= 1'b0; more_q <= 1'b0; pend_q <= 1'b0;
      busy_q <= 1'b0; wcnt_q <= '0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d; sel_q <= sel_d;
      adr_q <= adr_d; oe_q <= oe_d; more_q <= more_d; pend_q <= pend_d;
      busy_q <= busy_d; wcnt_q <= wcnt_d;
    end
  end

  assign sda_oe = oe_q;

  p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  p_release_mack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDAT_ACK) |-> !oe_q);
  p_quiet_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!oe_q && st_q == ST_IDLE));
  p_prog_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= CNT_LAST);
  p_sel_strap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEL_ACK && PAGE_SEL_BITS == 0) |-> (sel_q[3:1] == strap));
endmodule

// File: tb/ee_twi_target_tb.sv
module ee_twi_target_tb;
  localparam int PROG = 300;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int n_chk = 0, n_fail = 0, r10_viol = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic [7:0] wbuf [16];

  assign sda_line = sda_m & ~sda_oe;
  always #10 clk = ~clk;

  ee_twi_target #(.PAGE_SEL_BITS(0), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .strap(STRAP), .sda_oe(sda_oe));

  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl_m && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev <= sda_oe;
  end

  function automatic logic [7:0] sel_byte(input logic rw);
    return {4'b1010, STRAP, rw};
  endfunction
  function automatic logic [7:0] page_adr(input logic [7:0] a, input int i);
    return {a[7:3], 3'(int'(a[2:0]) + i)};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(6); sda_m = 1'b0; tick(6);
    scl_m = 1'b0; tick(2);
  endtask
  task automatic bstop();
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(6); sda_m = 1'b1; tick(6);
  endtask
  task automatic bit_out(input logic b);
    sda_m = b; tick(6); scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(2);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ackd);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(4); ackd = ~sda_line; tick(4);
    scl_m = 1'b0; tick(2);
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(6); scl_m = 1'b1; tick(4); b = {b[6:0], sda_line}; tick(4);
      scl_m = 1'b0; tick(2);
    end
    sda_m = ~mack; tick(6); scl_m = 1'b1; tick(4);
    chk(sda_oe == 1'b0, "R10 release in master ack slot", sda_oe, 0);
    tick(4); scl_m = 1'b0; tick(2); sda_m = 1'b1;
  endtask

  task automatic poll(input logic expect_busy);
    logic a;
    int nacks = 0;
    for (int k = 0; k < 40; k++) begin
      bstart(); send_byte(sel_byte(1'b0), a); bstop();
      if (a) break;
      nacks++;
    end
    if (expect_busy) chk(nacks > 0, "R5 select ignored while programming", nacks, 1);
    else chk(nacks == 0, "R9 no programming after abort", nacks, 0);
    chk(nacks < 40, "R5 select acknowledged after interval", nacks, 0);
  endtask

  task automatic write_page(input logic [7:0] a, input int n);
    logic ak;
    bstart(); send_byte(sel_byte(1'b0), ak); chk(ak, "R1 select ack", ak, 1);
    send_byte(a, ak); chk(ak, "R3 word address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      chk(ak, "R3 data ack", ak, 1);
      ref_mem[page_adr(a, i)] = wbuf[i];
    end
    bstop();
    ref_ptr = page_adr(a, n);
    poll(1'b1);
  endtask

  task automatic read_from(input logic [7:0] a, input int n, input string tag);
    logic ak;
    logic [7:0] d;
    bstart(); send_byte(sel_byte(1'b0), ak); send_byte(a, ak);
    bstart(); send_byte(sel_byte(1'b1), ak); chk(ak, "R7 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == ref_mem[8'(a + i)], tag, d, ref_mem[8'(a + i)]);
    end
    bstop();
    ref_ptr = 8'(a + n);
  endtask

  task automatic read_cur(input int n, input string tag);
    logic ak;
    logic [7:0] d;
    bstart(); send_byte(sel_byte(1'b1), ak); chk(ak, "R6 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == ref_mem[8'(ref_ptr + i)], tag, d, ref_mem[8'(ref_ptr + i)]);
    end
    bstop();
    ref_ptr = 8'(ref_ptr + n);
  endtask

  initial begin
    int unsigned seed;
    logic ak, ak2;
    seed = $urandom(32'd7341);
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_ptr = 8'h00;
    tick(5);
    chk(sda_oe == 1'b0, "R11 drive released in reset", sda_oe, 0);
    rst_n = 1'b1; tick(5);
    chk(sda_oe == 1'b0, "R11 drive released after reset", sda_oe, 0);
    read_cur(2, "R11 cleared array from pointer 0");

    bstart(); send_byte({4'b1010, 3'b100, 1'b0}, ak); send_byte(8'h00, ak2); bstop();
    chk(!ak, "R2 strap mismatch not acked", ak, 0);
    chk(!ak2, "R2 later byte ignored", ak2, 0);
    bstart(); send_byte({4'b1011, STRAP, 1'b0}, ak); bstop();
    chk(!ak, "R2 prefix mismatch not acked", ak, 0);

    wbuf[0] = 8'h5A; write_page(8'h10, 1);
    read_from(8'h10, 1, "R3 byte write readback");

    for (int i = 0; i < 10; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_page(8'h25, 10);
    read_from(8'h20, 8, "R4 page wrap contents");
    read_cur(3, "R6 current address read");

    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; write_page(8'hFE, 2);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; write_page(8'h00, 2);
    read_from(8'hFE, 4, "R8 sequential read across array wrap");

    bstart(); send_byte(sel_byte(1'b0), ak); send_byte(8'h40, ak);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bstop();
    poll(1'b0);
    read_from(8'h40, 1, "R9 memory unchanged after abort");

    for (int it = 0; it < 12; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = 1 + int'($urandom % 12);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_page(a, n);
      read_from(8'($urandom), 1 + int'($urandom % 5), "R7 random read");
      read_cur(2, "R6 pointer carry");
      read_from(a, 3, "R8 sequential read");
    end

    chk(r10_viol == 0, "R10 drive changes only with SCL low", r10_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule